// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Logging

This block sits behind a page-table walker. When the walker presents a leaf entry, the block combines the entry's 3-bit access field with the kind of access (read, write, instruction fetch or write-with-fetch) and the privilege level of the requester. From these it decides in the same cycle whether the access is legal and which read/write/execute rights may be granted for the page.

When an access is refused, the block records the fault. The fault status register captures the access index, the error class, a valid flag and an overflow flag. The fault address register captures the page-aligned virtual address. Unless a no-fault mode is active or traps are disabled, the block also raises a one-cycle trap request. That request carries a flag telling instruction faults from data faults. Software reads the status register through a read strobe, and the read clears it, so the overflow flag can show that a second fault arrived before the first was collected.

Write rights are granted only for pages whose modified bit is already set. A first write to a clean page therefore comes back to the walker, which can mark the page modified.

Top module: `mmu_access_guard`

## Requirements
- R1: With `chk_valid` high, the error class is 12 (privilege) for a user access (`chk_super`=0) to access field 6 or 7. Otherwise it is 8 (protection) when a needed right is missing from the field's rights, and 0 when none is missing. A read needs R, a fetch needs X, a write needs W, and write-with-fetch needs both W and X. `chk_kind` bit 0 marks write and bit 1 marks fetch, so `chk_kind`=0 is a read.
- R2: The rights of an access field are the same for both privilege levels for fields 0..4: 0=R, 1=RW, 2=RX, 3=RWX, 4=X. For user accesses, field 5 gives R and fields 6 and 7 give nothing. For supervisor accesses, field 5 gives RW, 6 gives RX and 7 gives RWX. `perm_rwx` bit 0 is read, bit 1 is write and bit 2 is execute, and it is 0 when `chk_valid` is low.
- R3: On an access that does not fault, write permission is removed from `perm_rwx` when `chk_modified` is 0.
- R4: With `nf_mode` high, a user access never faults. Its error class is ignored, no trap is raised, the status and address registers keep their values, and the R2/R3 rights are granted.
- R5: On a fault the status register is rebuilt from its old value. If the old value was nonzero and was not read in the same cycle, the base is 1; otherwise the base is 0. The base is then ORed with (index << 5) | class | 2, where index = write*4 + fetch*2 + supervisor. The new value is visible on `fsr_q` after the next clock edge.
- R6: On every fault, `far_q` is loaded with `chk_vpage` shifted up by PG_SHIFT bits, so its low bits are zero. Without a fault, `far_q` holds its value.
- R7: A fault with `nf_mode` low and `traps_en` high raises `trap_req` for exactly the cycle after the fault edge. `trap_ifetch` then equals the access's fetch bit; it is 0 whenever `trap_req` is 0. In the fault cycle `perm_rwx` is 0.
- R8: A fault with `nf_mode` high (supervisor access) or `traps_en` low raises no trap. It grants `perm_rwx`=RWX (7) and is still logged per R5 and R6.
- R9: A `fsr_rd` pulse clears `fsr_q` to 0 at the next edge. If a fault arrives in the same cycle, the new record is stored without the overflow flag.
- R10: After reset, `fsr_q` and `far_q` are 0 and `trap_req` is low. Reset is asserted asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A leaf entry is presented for checking this cycle |
| chk_acc | input | 3 | Access field of the leaf entry |
| chk_kind | input | 2 | Access kind: bit 0 write, bit 1 fetch |
| chk_super | input | 1 | 1 for a supervisor access, 0 for a user access |
| chk_modified | input | 1 | Modified bit of the leaf entry |
| chk_vpage | input | VA_W-PG_SHIFT | Virtual page number of the access |
| nf_mode | input | 1 | No-fault mode enable |
| traps_en | input | 1 | Traps enabled |
| fsr_rd | input | 1 | Software read strobe for the status register (clears it) |
| perm_rwx | output | 3 | Granted rights: bit 0 R, bit 1 W, bit 2 X |
| trap_req | output | 1 | One-cycle trap request |
| trap_ifetch | output | 1 | 1 for an instruction fault, 0 for a data fault |
| fsr_q | output | 8 | Fault status register |
| far_q | output | VA_W | Fault address register (page aligned) |

## Verification
On every cycle, the assertions check the following:
- a clean page never receives write rights outside the no-trap override;
- a user access in no-fault mode neither traps nor disturbs the status register;
- each fault sets the valid flag and the access index, and sets overflow when an unread record was present;
- the address register loads exactly on faults;
- the trap pulse and its fetch flag follow the fault and trap conditions.

The full 8-by-8 error-class map, the per-privilege rights tables and the exact status bytes can only be shown by the bench. It sweeps every combination of access field, kind, privilege, modified bit, no-fault mode and trap enable. Dedicated sequences cover back-to-back faults and a fault that coincides with a read.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

  localparam int FSR_W = 8;

  typedef enum logic [3:0] {
    EC_NONE = 4'd0,
    EC_PROT = 4'd8,
    EC_PRIV = 4'd12
  } err_code_e;

  // bit 0 read, bit 1 write, bit 2 execute
  typedef logic [2:0] rwx_t;

  localparam rwx_t RT_NONE = 3'b000;
  localparam rwx_t RT_R    = 3'b001;
  localparam rwx_t RT_W    = 3'b010;
  localparam rwx_t RT_X    = 3'b100;
  localparam rwx_t RT_ALL  = 3'b111;

  function automatic rwx_t field_rights(input logic [2:0] acc, input logic sup);
    rwx_t r;
    case (acc)
      3'd0:    r = RT_R;
      3'd1:    r = RT_R | RT_W;
      3'd2:    r = RT_R | RT_X;
      3'd3:    r = RT_ALL;
      3'd4:    r = RT_X;
      3'd5:    r = sup ? (RT_R | RT_W) : RT_R;
      3'd6:    r = sup ? (RT_R | RT_X) : RT_NONE;
      default: r = sup ? RT_ALL : RT_NONE;
    endcase
    return r;
  endfunction

  // kind bit 0 = write, bit 1 = fetch; neither = read
  function automatic rwx_t needed_rights(input logic [1:0] kind);
    rwx_t n;
    n = RT_NONE;
    if (kind[0]) n = n | RT_W;
    if (kind[1]) n = n | RT_X;
    if (kind == 2'b00) n = RT_R;
    return n;
  endfunction

endpackage

// File: rtl/mmu_perm_decode.sv
module mmu_perm_decode
  import mmu_guard_pkg::*;
(
  input  logic [2:0] acc,
  input  logic [1:0] kind,
  input  logic       sup,
  output err_code_e  err_code,
  output rwx_t       rights
);

  rwx_t need;
  logic priv_block;

  always_comb begin
    rights     = field_rights(acc, sup);
    need       = needed_rights(kind);
    priv_block = !sup && (acc[2:1] == 2'b11);
    if (priv_block)
      err_code = EC_PRIV;
    else if ((need & ~rights) != RT_NONE)
      err_code = EC_PROT;
    else
      err_code = EC_NONE;
  end

endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_guard_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   log_en,
  input  logic [2:0]             idx,
  input  err_code_e              ec,
  input  logic [VA_W-PG_SHIFT-1:0] vpage,
  input  logic                   rd_clr,
  output logic [FSR_W-1:0]       fsr_q,
  output logic [VA_W-1:0]        far_q
);

  logic [FSR_W-1:0] fsr_d;
  logic [VA_W-1:0]  far_d;
  logic             fsr_en;

  always_comb begin
    fsr_en = log_en | rd_clr;
    fsr_d  = rd_clr ? '0 : fsr_q;
    if (log_en) begin
      fsr_d = (fsr_q != '0 && !rd_clr) ? FSR_W'(1) : '0;
      fsr_d = fsr_d | {idx, 5'b0} | {4'b0, ec} | FSR_W'(2);
    end
    far_d = {vpage, {PG_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (fsr_en) fsr_q <= fsr_d;
      if (log_en) far_q <= far_d;
    end
  end

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_en && (fsr_q != '0) && !rd_clr |=> fsr_q[0]);

  // R5
  fsr_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> fsr_q[1] && (fsr_q[7:5] == $past(idx)));

  // R6
  far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> (far_q[PG_SHIFT-1:0] == '0) && (far_q[VA_W-1:PG_SHIFT] == $past(vpage)));

  // R6
  far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !log_en |=> $stable(far_q));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !log_en |=> fsr_q == '0);

endmodule

// File: rtl/mmu_trap_gen.sv
module mmu_trap_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic is_fetch,
  output logic trap_req,
  output logic trap_ifetch
);

  logic req_d;
  logic ifetch_d;

  always_comb begin
    req_d    = fire;
    ifetch_d = fire & is_fetch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req    <= 1'b0;
      trap_ifetch <= 1'b0;
    end else begin
      trap_req    <= req_d;
      trap_ifetch <= ifetch_d;
    end
  end

  // R7
  trap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trap_req && (trap_ifetch == $past(is_fetch)));

  // R7
  trap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !trap_req);

  // R7
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> !trap_ifetch);

endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_guard_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_valid,
  input  logic [2:0]               chk_acc,
  input  logic [1:0]               chk_kind,
  input  logic                     chk_super,
  input  logic                     chk_modified,
  input  logic [VA_W-PG_SHIFT-1:0] chk_vpage,
  input  logic                     nf_mode,
  input  logic                     traps_en,
  input  logic                     fsr_rd,
  output logic [2:0]               perm_rwx,
  output logic                     trap_req,
  output logic                     trap_ifetch,
  output logic [7:0]               fsr_q,
  output logic [VA_W-1:0]          far_q
);

  logic      rst_meta_n;
  logic      rst_sync_n;
  err_code_e ec;
  rwx_t      base_rights;
  logic [2:0] acc_idx;
  logic      nf_skip;
  logic      fault;
  logic      no_trap;
  logic      fire;
  rwx_t      grant;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mmu_perm_decode u_decode (
    .acc      (chk_acc),
    .kind     (chk_kind),
    .sup      (chk_super),
    .err_code (ec),
    .rights   (base_rights)
  );

  always_comb begin
    acc_idx = {chk_kind[0], chk_kind[1], chk_super};
    nf_skip = nf_mode & ~chk_super;
    fault   = chk_valid && (ec != EC_NONE) && !nf_skip;
    no_trap = nf_mode | ~traps_en;
    fire    = fault & ~no_trap;
    if (!chk_valid)
      grant = RT_NONE;
    else if (fault)
      grant = no_trap ? RT_ALL : RT_NONE;
    else
      grant = chk_modified ? base_rights : (base_rights & ~RT_W);
    perm_rwx = grant;
  end

  mmu_fault_log #(
    .VA_W     (VA_W),
    .PG_SHIFT (PG_SHIFT)
  ) u_log (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .log_en (fault),
    .idx    (acc_idx),
    .ec     (ec),
    .vpage  (chk_vpage),
    .rd_clr (fsr_rd),
    .fsr_q  (fsr_q),
    .far_q  (far_q)
  );

  mmu_trap_gen u_trap (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fire        (fire),
    .is_fetch    (chk_kind[1]),
    .trap_req    (trap_req),
    .trap_ifetch (trap_ifetch)
  );

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_valid && !chk_modified && perm_rwx[1] |-> (nf_mode || !traps_en));

  // R4
  nf_user_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_valid && nf_mode && !chk_super |=> !trap_req);

  // R4
  nf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_valid && nf_mode && !chk_super && !fsr_rd |=> $stable(fsr_q));

  // R1
  priv_deny_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_valid && !chk_super && (chk_acc[2:1] == 2'b11) && !nf_mode && traps_en
      |-> perm_rwx == 3'b000);

endmodule

// File: tb/mmu_access_guard_tb_top.sv
`timescale 1ns/1ps
module mmu_access_guard_tb_top;

  localparam int VA_W = 32;
  localparam int PG_SHIFT = 12;
  localparam int VP_W = VA_W - PG_SHIFT;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            chk_valid = 1'b0;
  logic [2:0]      chk_acc = '0;
  logic [1:0]      chk_kind = '0;
  logic            chk_super = 1'b0;
  logic            chk_modified = 1'b0;
  logic [VP_W-1:0] chk_vpage = '0;
  logic            nf_mode = 1'b0;
  logic            traps_en = 1'b0;
  logic            fsr_rd = 1'b0;
  logic [2:0]      perm_rwx;
  logic            trap_req;
  logic            trap_ifetch;
  logic [7:0]      fsr_q;
  logic [VA_W-1:0] far_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmu_access_guard #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_acc(chk_acc),
    .chk_kind(chk_kind), .chk_super(chk_super), .chk_modified(chk_modified),
    .chk_vpage(chk_vpage), .nf_mode(nf_mode), .traps_en(traps_en),
    .fsr_rd(fsr_rd), .perm_rwx(perm_rwx), .trap_req(trap_req),
    .trap_ifetch(trap_ifetch), .fsr_q(fsr_q), .far_q(far_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the rights per R2, built as masks
  function automatic logic [2:0] m_rights(input int acc, input bit sup);
    logic [2:0] t [8];
    t[0] = 3'd1; t[1] = 3'd3; t[2] = 3'd5; t[3] = 3'd7; t[4] = 3'd4;
    t[5] = sup ? 3'd3 : 3'd1;
    t[6] = sup ? 3'd5 : 3'd0;
    t[7] = sup ? 3'd7 : 3'd0;
    return t[acc];
  endfunction

  function automatic int m_class(input int acc, input int kind, input bit sup);
    logic [2:0] need;
    need = 3'd0;
    if (kind % 2 == 1) need = need + 3'd2;
    if (kind >= 2) need = need + 3'd4;
    if (kind == 0) need = 3'd1;
    if (!sup && acc >= 6) return 12;
    if ((need & ~m_rights(acc, sup)) != 0) return 8;
    return 0;
  endfunction

  task automatic clear_fsr();
    @(negedge clk);
    chk_valid = 1'b0;
    fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VA_W-1:0] exp_far;
    exp_far = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 fsr", fsr_q, 0);
    check("R10 far", far_q, 0);
    check("R10 trap", trap_req, 0);

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int it = 0; it < 512; it++) begin
      int acc; int kind; bit sup; bit md; bit nf; bit ten;
      int ec; bit flt; bit ntr; logic [2:0] pexp; int idx;
      logic [VP_W-1:0] vp;
      acc = it % 8; kind = (it / 8) % 4; sup = it[5]; md = it[6];
      nf = it[7]; ten = it[8];
      vp = VP_W'(20'hA5C3 ^ (it * 20'h0137F));
      ec = m_class(acc, kind, sup);
      flt = (ec != 0) && !(nf && !sup);
      ntr = nf || !ten;
      if (flt) pexp = ntr ? 3'd7 : 3'd0;
      else pexp = md ? m_rights(acc, sup) : (m_rights(acc, sup) & 3'b101);
      idx = (kind % 2) * 4 + (kind / 2) * 2 + int'(sup);
      @(negedge clk);
      chk_valid = 1'b1; chk_acc = 3'(acc); chk_kind = 2'(kind);
      chk_super = sup; chk_modified = md; chk_vpage = vp;
      nf_mode = nf; traps_en = ten;
      #1;
      if (flt) check(ntr ? "R8 perm override" : "R7 perm on trap", perm_rwx, pexp);
      else if (nf && !sup) check("R4 perm nf user", perm_rwx, pexp);
      else check("R1 R2 R3 perm", perm_rwx, pexp);
      @(negedge clk);
      chk_valid = 1'b0;
      check("R7 trap_req", trap_req, flt && !ntr);
      check("R7 trap_ifetch", trap_ifetch, flt && !ntr && kind >= 2);
      check("R5 fsr", fsr_q, flt ? ((idx << 5) | ec | 2) : 0);
      if (flt) exp_far = {vp, {PG_SHIFT{1'b0}}};
      check("R6 far", far_q, exp_far);
      fsr_rd = 1'b1;
      @(negedge clk);
      fsr_rd = 1'b0;
      check("R9 fsr cleared", fsr_q, 0);
      check("R7 pulse ends", trap_req, 0);
    end

    // R5 overflow: two faults without a read
    nf_mode = 1'b0; traps_en = 1'b1;
    @(negedge clk);
    chk_valid = 1'b1; chk_acc = 3'd4; chk_kind = 2'd0; chk_super = 1'b0;
    chk_modified = 1'b1; chk_vpage = 20'h00011;
    @(negedge clk);
    check("R5 first record", fsr_q, 8'h0A);
    chk_acc = 3'd0; chk_kind = 2'd1; chk_super = 1'b1; chk_vpage = 20'h00022;
    @(negedge clk);
    chk_valid = 1'b0;
    check("R5 overflow record", fsr_q, 8'hAB);
    check("R6 far second", far_q, 32'h0002_2000);
    check("R7 back-to-back trap", trap_req, 1);

    // R9 fault arriving with a read: no overflow
    @(negedge clk);
    chk_valid = 1'b1; chk_acc = 3'd0; chk_kind = 2'd2; chk_super = 1'b0;
    fsr_rd = 1'b1; chk_vpage = 20'hFFFFF;
    @(negedge clk);
    chk_valid = 1'b0; fsr_rd = 1'b0;
    check("R9 read with fault", fsr_q, 8'h4A);
    check("R7 fetch flag", trap_ifetch, 1);
    check("R6 far top page", far_q, 32'hFFFF_F000);

    // R4 nf user fault leaves registers untouched
    @(negedge clk);
    nf_mode = 1'b1;
    chk_valid = 1'b1; chk_acc = 3'd6; chk_kind = 2'd0; chk_super = 1'b0;
    chk_vpage = 20'h12345;
    #1;
    check("R4 perm none", perm_rwx, 0);
    @(negedge clk);
    chk_valid = 1'b0;
    check("R4 fsr kept", fsr_q, 8'h4A);
    check("R4 far kept", far_q, 32'hFFFF_F000);
    check("R4 no trap", trap_req, 0);

    // R2 valid low gives no rights
    nf_mode = 1'b0;
    chk_acc = 3'd3; chk_super = 1'b1; #1;
    check("R2 idle perm", perm_rwx, 0);
    clear_fsr();
    check("R9 final clear", fsr_q, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule